// File: doc/BRIEF.md
# Subcode Shift Clock Generator and Symbol Receiver

This block sits between a disc DSP and the subcode text decoder. Every subcode frame, the DSP announces the frame with a frame-sync edge and then shifts out one 8-bit symbol. The symbol holds channels P to W, with P first. The block either produces the shift clock for that transfer or follows a shift clock that another device drives. It samples the serial data on each rising shift edge and passes on the six R to W bits with a one-cycle strobe.

When the block drives the clock, all timing is counted in master-clock cycles from the frame-sync edge. A static speed input selects between two timings. Normal speed uses a long lead-in delay and wide clock phases. Double speed uses a shorter delay and narrower phases, for discs played at twice the rate. A static direction input chooses between driving the clock and following an external one. Frame sync, external clock and serial data all pass through a two-flop synchronizer before use.

Top module: `subcode_shift_clk`

## Requirements
- R1: With `dir_sel` low, `sclk_oe` is high from the first clock after reset. With `dir_sel` high, `sclk_oe` and `sclk_out` stay low, and frame sync produces no clock.
- R2: In double-speed mode (`speed_sel` low), `sclk_out` first goes high 208 cycles after the first clock edge that samples `frame_sync` high following a low.
- R3: In double-speed mode, each high phase and each low phase of `sclk_out` lasts 32 cycles.
- R4: In normal-speed mode (`speed_sel` high), `sclk_out` first goes high 320 cycles after the first clock edge that samples `frame_sync` high.
- R5: In normal-speed mode, each high phase and each low phase of `sclk_out` lasts 128 cycles.
- R6: The generated clock has exactly 8 rising edges per frame sync. After the eighth high phase it stays low until the next frame sync.
- R7: The first sampled bit is P and the eighth is W. `sym_data[5]` carries the third bit (R) and `sym_data[0]` carries the eighth (W). `sym_data` holds its value between strobes.
- R8: In generated mode, each rising edge of `sclk_out` samples `sdata` as it stood two clock edges earlier. `sym_valid` is high for exactly the one cycle after the edge that raises the eighth pulse.
- R9: In external mode, a rise of `sclk_in` first seen at clock edge m samples `sdata` at edge m. The eighth such rise raises `sym_valid` for one cycle after edge m+2.
- R10: In external mode, a frame-sync rise discards a partly received symbol. Clock rises after the eighth are ignored until the next frame sync.
- R11: In generated mode, activity on `sclk_in` has no effect on any output.
- R12: While `rst` is high, `sclk_out`, `sclk_oe`, `sym_valid` and `sym_data` are all low at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_sel | input | 1 | 0: block drives the shift clock, 1: shift clock comes from outside |
| speed_sel | input | 1 | 0: double-speed timing, 1: normal-speed timing |
| frame_sync | input | 1 | Frame sync from the DSP; a rising edge starts a frame |
| sdata | input | 1 | Serial subcode data |
| sclk_in | input | 1 | External shift clock (used when `dir_sel` is high) |
| sclk_out | output | 1 | Generated shift clock |
| sclk_oe | output | 1 | High when `sclk_out` should drive the shared clock line |
| sym_valid | output | 1 | One-cycle strobe marking a new R to W value |
| sym_data | output | 6 | R to W bits, R in bit 5 |

## Verification
A wrong delay count or phase count shows on `sclk_out` at the very first rising edge after a frame sync. The reference model compares that pin on every cycle, so the error is caught within one cycle. A bit counter that slips or misses a clear shows as a `sym_valid` strobe in the wrong cycle, or a missing one. This happens no later than the eighth sample of the affected frame, and the resync and extra-pulse sequences in external mode target exactly that case. A broken shift path shows as a wrong `sym_data` value on the cycle the strobe is high.

// File: rtl/subcode_shift_clk_pkg.sv
package subcode_shift_clk_pkg;

  typedef enum logic [1:0] {
    BST_IDLE,
    BST_WAIT,
    BST_HIGH,
    BST_LOW
  } burst_state_t;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/scg_sync.sv
module scg_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/scg_burst_timer.sv
module scg_burst_timer
  import subcode_shift_clk_pkg::*;
#(
  parameter int unsigned DLY_DBL   = 208,
  parameter int unsigned HALF_DBL  = 32,
  parameter int unsigned DLY_NRM   = 320,
  parameter int unsigned HALF_NRM  = 128,
  parameter int unsigned PULSES    = 8,
  parameter int unsigned START_CNT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic start,
  input  logic speed_nrm,
  output logic sclk_q,
  output logic fire
);

  localparam int unsigned MAXV = umax(umax(DLY_DBL, DLY_NRM), umax(HALF_DBL, HALF_NRM));
  localparam int unsigned CW   = $clog2(MAXV + 1);
  localparam int unsigned PW   = $clog2(PULSES + 1);

  burst_state_t  st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] dly_q;
  logic [CW-1:0] half_q;
  logic [PW-1:0] npulse;
  logic          at_dly;
  logic          at_half;

  assign at_dly  = (cnt == dly_q - CW'(1));
  assign at_half = (cnt == half_q - CW'(1));

  always_comb begin
    fire = enable && !start &&
           (((st == BST_WAIT) && at_dly) || ((st == BST_LOW) && at_half));
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      st     <= BST_IDLE;
      cnt    <= '0;
      sclk_q <= 1'b0;
      npulse <= '0;
      dly_q  <= '0;
      half_q <= '0;
    end else if (start) begin
      st     <= BST_WAIT;
      cnt    <= CW'(START_CNT);
      sclk_q <= 1'b0;
      npulse <= '0;
      dly_q  <= speed_nrm ? CW'(DLY_NRM)  : CW'(DLY_DBL);
      half_q <= speed_nrm ? CW'(HALF_NRM) : CW'(HALF_DBL);
    end else begin
      case (st)
        BST_WAIT: begin
          if (at_dly) begin
            sclk_q <= 1'b1;
            st     <= BST_HIGH;
            cnt    <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        BST_HIGH: begin
          if (at_half) begin
            sclk_q <= 1'b0;
            cnt    <= '0;
            npulse <= npulse + PW'(1);
            st     <= (npulse == PW'(PULSES - 1)) ? BST_IDLE : BST_LOW;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        BST_LOW: begin
          if (at_half) begin
            sclk_q <= 1'b1;
            st     <= BST_HIGH;
            cnt    <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= BST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scg_symbol_asm.sv
module scg_symbol_asm #(
  parameter int unsigned BITS  = 8,
  parameter int unsigned OUT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             sample,
  input  logic             bit_in,
  output logic             sym_valid,
  output logic [OUT_W-1:0] sym_data
);

  localparam int unsigned BCW = $clog2(BITS + 1);

  logic [BITS-2:0] shreg;
  logic [BCW-1:0]  nbits;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      nbits     <= '0;
      sym_valid <= 1'b0;
      sym_data  <= '0;
    end else if (clear) begin
      nbits     <= '0;
      sym_valid <= 1'b0;
    end else if (sample && (nbits < BCW'(BITS))) begin
      shreg <= {shreg[BITS-3:0], bit_in};
      nbits <= nbits + BCW'(1);
      if (nbits == BCW'(BITS - 1)) begin
        sym_valid <= 1'b1;
        sym_data  <= {shreg[OUT_W-2:0], bit_in};
      end else begin
        sym_valid <= 1'b0;
      end
    end else begin
      sym_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/subcode_shift_clk.sv
module subcode_shift_clk #(
  parameter int unsigned DLY_DBL     = 208,
  parameter int unsigned HALF_DBL    = 32,
  parameter int unsigned DLY_NRM     = 320,
  parameter int unsigned HALF_NRM    = 128,
  parameter int unsigned SYM_BITS    = 8,
  parameter int unsigned OUT_W       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_sel,
  input  logic             speed_sel,
  input  logic             frame_sync,
  input  logic             sdata,
  input  logic             sclk_in,
  output logic             sclk_out,
  output logic             sclk_oe,
  output logic             sym_valid,
  output logic [OUT_W-1:0] sym_data
);

  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0] sync_q;
  logic fs_s, ck_s, sd_s;
  logic fs_prev, ck_prev, oe_q;
  logic fs_rise, ck_rise;
  logic gen_fire, gen_sclk, take_bit;

  scg_sync #(.STAGES(SYNC_STAGES), .W(NSYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({frame_sync, sclk_in, sdata}),
    .q   (sync_q)
  );

  assign fs_s = sync_q[2];
  assign ck_s = sync_q[1];
  assign sd_s = sync_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_prev <= 1'b0;
      ck_prev <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      fs_prev <= fs_s;
      ck_prev <= ck_s;
      oe_q    <= !dir_sel;
    end
  end

  assign fs_rise = fs_s && !fs_prev;
  assign ck_rise = ck_s && !ck_prev;

  scg_burst_timer #(
    .DLY_DBL   (DLY_DBL),
    .HALF_DBL  (HALF_DBL),
    .DLY_NRM   (DLY_NRM),
    .HALF_NRM  (HALF_NRM),
    .PULSES    (SYM_BITS),
    .START_CNT (SYNC_STAGES)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .enable    (!dir_sel),
    .start     (fs_rise),
    .speed_nrm (speed_sel),
    .sclk_q    (gen_sclk),
    .fire      (gen_fire)
  );

  assign take_bit = dir_sel ? ck_rise : gen_fire;

  scg_symbol_asm #(.BITS(SYM_BITS), .OUT_W(OUT_W)) u_asm (
    .clk       (clk),
    .rst       (rst),
    .clear     (fs_rise),
    .sample    (take_bit),
    .bit_in    (sd_s),
    .sym_valid (sym_valid),
    .sym_data  (sym_data)
  );

  assign sclk_out = gen_sclk;
  assign sclk_oe  = oe_q;

endmodule

// File: rtl/subcode_shift_clk_chk.sv
module subcode_shift_clk_chk #(
  parameter int unsigned HALF_MAX = 128,
  parameter int unsigned OUT_W    = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             dir_sel,
  input logic             sclk_out,
  input logic             sclk_oe,
  input logic             sym_valid,
  input logic [OUT_W-1:0] sym_data
);

  localparam int unsigned RW = $clog2(HALF_MAX + 2);

  logic          armed;
  logic [RW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      hi_run <= '0;
    end else begin
      armed  <= 1'b1;
      hi_run <= sclk_out ? hi_run + RW'(1) : '0;
    end
  end

  assert_oe_follow_R1: assert property (@(posedge clk) disable iff (rst)
    armed |-> (sclk_oe == !$past(dir_sel)));

  assert_ext_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(dir_sel)) |-> !sclk_out);

  assert_high_width_R5: assert property (@(posedge clk) disable iff (rst)
    sclk_out |-> (hi_run < RW'(HALF_MAX)));

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
    sym_valid |=> !sym_valid);

  assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (armed && !sym_valid) |-> $stable(sym_data));

  assert_reset_quiet_R12: assert property (@(posedge clk)
    rst |=> (!sclk_out && !sclk_oe && !sym_valid && (sym_data == '0)));

endmodule

bind subcode_shift_clk subcode_shift_clk_chk #(
  .HALF_MAX (HALF_NRM),
  .OUT_W    (OUT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dir_sel   (dir_sel),
  .sclk_out  (sclk_out),
  .sclk_oe   (sclk_oe),
  .sym_valid (sym_valid),
  .sym_data  (sym_data)
);

// File: tb/subcode_shift_clk_tb.sv
module subcode_shift_clk_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dir_sel = 1'b0;
  logic       speed_sel = 1'b0;
  logic       frame_sync = 1'b0;
  logic       sdata = 1'b0;
  logic       sclk_in = 1'b0;
  logic       sclk_out, sclk_oe, sym_valid;
  logic [5:0] sym_data;

  always #5 clk = ~clk;

  subcode_shift_clk u_dut (
    .clk        (clk),
    .rst        (rst),
    .dir_sel    (dir_sel),
    .speed_sel  (speed_sel),
    .frame_sync (frame_sync),
    .sdata      (sdata),
    .sclk_in    (sclk_in),
    .sclk_out   (sclk_out),
    .sclk_oe    (sclk_oe),
    .sym_valid  (sym_valid),
    .sym_data   (sym_data)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // behavioural reference state, advanced on every rising edge
  int   cyc = 0;
  int   t_fs = -100000;
  int   ext_cnt = 99;
  int   ext_valid_at = -1;
  bit   fs_prev = 1'b0, ck_prev = 1'b0;
  bit   exp_oe = 1'b0, exp_sclk = 1'b0, exp_valid = 1'b0;
  bit   started = 1'b0;
  logic [7:0] exp_byte = 8'h00;
  int   valid_seen = 0;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    int d, dl, hf;
    cyc++;
    started = 1'b1;
    dl = speed_sel ? 320 : 208;
    hf = speed_sel ? 128 : 32;
    if (rst) begin
      exp_oe = 0; exp_sclk = 0; exp_valid = 0;
      t_fs = -100000; ext_cnt = 99; ext_valid_at = -1;
    end else begin
      exp_oe = !dir_sel;
      if (frame_sync && !fs_prev) begin
        t_fs = cyc;
        ext_cnt = 0;
      end
      d = cyc - t_fs - dl;
      exp_sclk  = !dir_sel && d >= 0 && d < 16 * hf && ((d / hf) % 2 == 0);
      exp_valid = dir_sel ? (cyc == ext_valid_at) : (d == 14 * hf);
      if (dir_sel && sclk_in && !ck_prev) begin
        ext_cnt++;
        if (ext_cnt == 8) ext_valid_at = cyc + 2;
      end
    end
    fs_prev = frame_sync;
    ck_prev = sclk_in;
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R1 sclk_oe", sclk_oe, exp_oe);
      chk("R2 R3 R4 R5 R6 R11 sclk_out", sclk_out, exp_sclk);
      chk("R8 R9 R10 sym_valid", sym_valid, exp_valid);
      if (exp_valid) chk("R7 sym_data", sym_data, exp_byte[5:0]);
      if (sym_valid) valid_seen++;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      vectors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic do_reset(input bit dir, input bit spd);
    @(negedge clk);
    rst = 1'b1; dir_sel = dir; speed_sel = spd;
    frame_sync = 1'b0; sclk_in = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_gen(input logic [7:0] b, input int period);
    int k, first_rise, first_fall, rises, idx, v0, dl, hf;
    bit prev_s;
    dl = speed_sel ? 320 : 208;
    hf = speed_sel ? 128 : 32;
    exp_byte = b;
    idx = 0; rises = 0; first_rise = -1; first_fall = -1; prev_s = 0;
    v0 = valid_seen;
    @(negedge clk);
    sdata = b[7];
    frame_sync = 1'b1;
    k = cyc + 1;
    for (int i = 0; i < period; i++) begin
      @(negedge clk);
      if (i == 6) frame_sync = 1'b0;
      sclk_in = ((i % 7) < 3);   // R11: external clock noise must not matter
      if (sclk_out && !prev_s) begin
        rises++;
        if (first_rise < 0) first_rise = cyc;
      end
      if (!sclk_out && prev_s) begin
        if (first_fall < 0) first_fall = cyc;
        idx++;
        if (idx < 8) sdata = b[7 - idx];
      end
      prev_s = sclk_out;
    end
    sclk_in = 1'b0;
    chk(speed_sel ? "R4 first rise delay" : "R2 first rise delay", first_rise - k, dl);
    chk(speed_sel ? "R5 high phase" : "R3 high phase", first_fall - first_rise, hf);
    chk("R6 rising edges per frame", rises, 8);
    chk("R8 strobes per frame", valid_seen - v0, 1);
  endtask

  task automatic fs_pulse();
    @(negedge clk);
    frame_sync = 1'b1;
    repeat (6) @(negedge clk);
    frame_sync = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic ext_pulse(input bit b, input int half);
    @(negedge clk);
    sdata = b;
    repeat (4) @(negedge clk);
    sclk_in = 1'b1;
    repeat (half) @(negedge clk);
    sclk_in = 1'b0;
    repeat (half) @(negedge clk);
  endtask

  task automatic ext_byte(input logic [7:0] b, input int half);
    for (int i = 7; i >= 0; i--) ext_pulse(b[i], half);
  endtask

  initial begin
    int v0;
    repeat (3) @(negedge clk);
    chk("R12 reset sclk_out", sclk_out, 0);
    chk("R12 reset sclk_oe", sclk_oe, 0);
    chk("R12 reset sym_valid", sym_valid, 0);
    chk("R12 reset sym_data", sym_data, 0);

    // generated clock, double speed
    do_reset(1'b0, 1'b0);
    chk("R1 oe in generated mode", sclk_oe, 1);
    send_gen(8'hA5, 900);
    send_gen(8'h3C, 900);
    send_gen(8'hFF, 900);
    send_gen(8'h40, 900);

    // reset in the middle of a burst
    @(negedge clk);
    frame_sync = 1'b1;
    repeat (6) @(negedge clk);
    frame_sync = 1'b0;
    repeat (240) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R12 mid-burst reset sclk_out", sclk_out, 0);
    chk("R12 mid-burst reset sym_valid", sym_valid, 0);
    chk("R12 mid-burst reset sclk_oe", sclk_oe, 0);
    rst = 1'b0;
    repeat (400) @(negedge clk);

    // generated clock, normal speed
    do_reset(1'b0, 1'b1);
    send_gen(8'h96, 2600);
    send_gen(8'h01, 2600);

    // external clock
    do_reset(1'b1, 1'b0);
    chk("R1 oe in external mode", sclk_oe, 0);
    fs_pulse();
    chk("R1 no clock from frame sync", sclk_out, 0);
    exp_byte = 8'h00;
    for (int i = 0; i < 5; i++) ext_pulse(1'b1, 6);
    fs_pulse();
    v0 = valid_seen;
    exp_byte = 8'hC6;
    ext_byte(8'hC6, 6);
    repeat (4) @(negedge clk);
    chk("R10 one strobe after resync", valid_seen - v0, 1);
    v0 = valid_seen;
    for (int i = 0; i < 3; i++) ext_pulse(1'b0, 6);
    repeat (4) @(negedge clk);
    chk("R10 extra pulses ignored", valid_seen - v0, 0);
    chk("R7 data held", sym_data, 6'h06);
    fs_pulse();
    v0 = valid_seen;
    exp_byte = 8'h2B;
    ext_byte(8'h2B, 3);
    repeat (4) @(negedge clk);
    chk("R9 strobe with short external phases", valid_seen - v0, 1);

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule